// File: doc/BRIEF.md
# Masked Time-of-Day Alarm Comparator

This block decides, once per clock-calendar update, whether the current time has reached a programmed alarm time. It compares three live time bytes (seconds, minutes, hours) with three alarm bytes. When every field that takes part in the comparison is equal, it emits a one-cycle match pulse. That pulse goes to the interrupt flag logic elsewhere in the chip.

Any alarm byte can be turned into a wildcard by setting both of its top two bits. A wildcard field matches every current value. With one comparator this gives four alarm rates:
- a daily alarm, when no field is a wildcard;
- an hourly alarm, when the hours byte is a wildcard;
- a per-minute alarm, when the hours and minutes bytes are wildcards;
- a per-second alarm, when all three bytes are wildcards.

Bytes are compared raw. The block does not need to know whether the clock counts in BCD or in binary, or whether it runs in 12-hour or 24-hour form.

Top module: `tod_alarm_cmp`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `matchPulse` is 0.
- R2: When no alarm byte is a wildcard and all three current bytes equal their alarm bytes, a rising edge of `updDone` makes `matchPulse` 1 for the cycle after the edge is sampled.
- R3: If any non-wildcard alarm byte differs from its current byte, the update produces no pulse.
- R4: An alarm byte is a wildcard exactly when bits 7 and 6 are both 1 (values 0xC0 to 0xFF). A wildcard field matches any current value, and the low six bits of a wildcard byte have no effect.
- R5: With only the hours byte a wildcard, a pulse occurs whenever minutes and seconds match, whatever the current hour.
- R6: With the hours and minutes bytes as wildcards, a pulse occurs whenever seconds match.
- R7: With all three bytes as wildcards, every update produces a pulse.
- R8: No pulse is produced in a cycle whose previous sampled `updDone` was 0, even when all fields match.
- R9: `matchPulse` lasts one cycle. An `updDone` held high for several cycles yields at most one pulse until it returns to 0.
- R10: Bit 7 of the hours byte (the AM/PM flag in 12-hour form) takes part in the comparison. For example, alarm 0x81 does not match current 0x01. A hours alarm with bits 7:6 = 11 is still a wildcard.
- R11: Bytes are compared as raw 8-bit values with no range or format check. For example, 0x3B matches 0x3B, and 0x5A does not match 0x5B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| updDone | input | 1 | Update-complete strobe from the time counters; only its rising edge is used |
| curSec | input | 8 | Current seconds byte |
| curMin | input | 8 | Current minutes byte |
| curHour | input | 8 | Current hours byte, bit 7 being AM/PM in 12-hour form |
| almSec | input | 8 | Seconds alarm byte |
| almMin | input | 8 | Minutes alarm byte |
| almHour | input | 8 | Hours alarm byte |
| matchPulse | output | 1 | One-cycle alarm match pulse |

## Verification
The only state in the block is the previous strobe value and the registered match, so any fault shows up on `matchPulse` in the cycle right after an update edge.

| Fault | What appears on `matchPulse` |
|---|---|
| Stuck strobe-history bit | A missing pulse, or a repeated pulse while the strobe is held |
| Faulty field comparison | A pulse on the wrong update |
| Faulty wildcard decode | A pulse on the wrong update, seen when alarm bytes are drawn from both the wildcard and the non-wildcard ranges |

A random mix of alarm bytes across both ranges therefore exposes these faults within a few updates.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;

  // Strobes sent from the control to the datapath
  typedef struct packed {
    logic evalEn;    // evaluate the comparison this cycle
    logic clearOut;  // drop the match output this cycle
  } ctrlStrb_t;

endpackage

// File: rtl/tod_alarm_ctrl.sv
module tod_alarm_ctrl
  import tod_alarm_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      updDone,
  output ctrlStrb_t strb
);

  logic updPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) updPrev <= 1'b0;
    else       updPrev <= updDone;
  end

  always_comb begin
    strb.evalEn   = updDone & ~updPrev;
    strb.clearOut = ~strb.evalEn;
  end

endmodule

// File: rtl/tod_alarm_dp.sv
module tod_alarm_dp
  import tod_alarm_pkg::*;
#(
  parameter int FIELD_W    = 8,
  parameter int NUM_FIELDS = 3,
  parameter int WILD_BITS  = 2
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  ctrlStrb_t                           strb,
  input  logic [NUM_FIELDS-1:0][FIELD_W-1:0]  curVal,
  input  logic [NUM_FIELDS-1:0][FIELD_W-1:0]  almVal,
  output logic                                matchQ
);

  localparam int WILD_LO = FIELD_W - WILD_BITS;

  logic [NUM_FIELDS-1:0] fieldHit;
  logic                  allHit;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    logic isWild;
    assign isWild      = &almVal[f][FIELD_W-1:WILD_LO];
    assign fieldHit[f] = isWild | (almVal[f] == curVal[f]);
  end

  assign allHit = &fieldHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              matchQ <= 1'b0;
    else if (strb.clearOut) matchQ <= 1'b0;
    else if (strb.evalEn)   matchQ <= allHit;
  end

endmodule

// File: rtl/tod_alarm_cmp.sv
module tod_alarm_cmp
  import tod_alarm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       updDone,
  input  logic [7:0] curSec,
  input  logic [7:0] curMin,
  input  logic [7:0] curHour,
  input  logic [7:0] almSec,
  input  logic [7:0] almMin,
  input  logic [7:0] almHour,
  output logic       matchPulse
);

  localparam int FIELD_W    = 8;
  localparam int NUM_FIELDS = 3;

  ctrlStrb_t                          strb;
  logic [NUM_FIELDS-1:0][FIELD_W-1:0] curVal;
  logic [NUM_FIELDS-1:0][FIELD_W-1:0] almVal;

  assign curVal = {curHour, curMin, curSec};
  assign almVal = {almHour, almMin, almSec};

  tod_alarm_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .updDone (updDone),
    .strb    (strb)
  );

  tod_alarm_dp #(
    .FIELD_W    (FIELD_W),
    .NUM_FIELDS (NUM_FIELDS),
    .WILD_BITS  (2)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .curVal (curVal),
    .almVal (almVal),
    .matchQ (matchPulse)
  );

endmodule

// File: rtl/tod_alarm_chk.sv
module tod_alarm_chk (
  input logic       clk,
  input logic       rstN,
  input logic       updDone,
  input logic [7:0] curSec,
  input logic [7:0] curMin,
  input logic [7:0] curHour,
  input logic [7:0] almSec,
  input logic [7:0] almMin,
  input logic [7:0] almHour,
  input logic       matchPulse
);

  a_r1_reset_quiet: assert property (@(posedge clk) !rstN |=> !matchPulse);

  a_r8_needs_strobe: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |-> $past(updDone));

  a_r9_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |=> !matchPulse);

  a_r3_sec_mismatch: assert property (@(posedge clk) disable iff (!rstN)
    (updDone && (almSec[7:6] != 2'b11) && (almSec != curSec)) |=> !matchPulse);

  a_r10_hour_mismatch: assert property (@(posedge clk) disable iff (!rstN)
    (updDone && (almHour[7:6] != 2'b11) && (almHour != curHour)) |=> !matchPulse);

  a_r7_all_wild: assert property (@(posedge clk) disable iff (!rstN)
    (updDone && !$past(updDone) && (almSec[7:6] == 2'b11) &&
     (almMin[7:6] == 2'b11) && (almHour[7:6] == 2'b11)) |=> matchPulse);

endmodule

bind tod_alarm_cmp tod_alarm_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .updDone    (updDone),
  .curSec     (curSec),
  .curMin     (curMin),
  .curHour    (curHour),
  .almSec     (almSec),
  .almMin     (almMin),
  .almHour    (almHour),
  .matchPulse (matchPulse)
);

// File: tb/tb_tod_alarm_cmp.sv
module tb_tod_alarm_cmp;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       updDone = 1'b0;
  logic [7:0] curSec = 8'h00, curMin = 8'h00, curHour = 8'h00;
  logic [7:0] almSec = 8'h00, almMin = 8'h00, almHour = 8'h00;
  logic       matchPulse;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tod_alarm_cmp dut (
    .clk(clk), .rstN(rstN), .updDone(updDone),
    .curSec(curSec), .curMin(curMin), .curHour(curHour),
    .almSec(almSec), .almMin(almMin), .almHour(almHour),
    .matchPulse(matchPulse)
  );

  function automatic bit fieldOk(input logic [7:0] a, input logic [7:0] c);
    return (a[7:6] == 2'b11) || (a == c);
  endfunction

  function automatic bit expMatch();
    return fieldOk(almSec, curSec) && fieldOk(almMin, curMin) && fieldOk(almHour, curHour);
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: matchPulse=%0b expected=%0b (alm %h %h %h cur %h %h %h)",
               req, act, exp, almHour, almMin, almSec, curHour, curMin, curSec);
    end
  endtask

  task automatic setAll(input logic [7:0] ah, am, as_, ch, cm, cs);
    almHour = ah; almMin = am; almSec = as_;
    curHour = ch; curMin = cm; curSec = cs;
  endtask

  // One-cycle strobe; check the pulse and that it drops a cycle later.
  task automatic update(input string req, input logic exp);
    @(negedge clk);
    updDone = 1'b1;
    @(negedge clk);
    updDone = 1'b0;
    check(req, matchPulse, exp);
    @(negedge clk);
    check("R9", matchPulse, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    setAll(8'h12, 8'h30, 8'h45, 8'h12, 8'h30, 8'h45);
    updDone = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", matchPulse, 1'b0);
    updDone = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    check("R1", matchPulse, 1'b0);

    // R2 daily exact
    setAll(8'h07, 8'h15, 8'h30, 8'h07, 8'h15, 8'h30); update("R2", 1'b1);
    // R3 single-field mismatches
    setAll(8'h07, 8'h15, 8'h30, 8'h07, 8'h15, 8'h31); update("R3", 1'b0);
    setAll(8'h07, 8'h15, 8'h30, 8'h07, 8'h16, 8'h30); update("R3", 1'b0);
    setAll(8'h07, 8'h15, 8'h30, 8'h08, 8'h15, 8'h30); update("R3", 1'b0);
    // R4 wildcard low bits ignored
    setAll(8'h07, 8'h15, 8'hFF, 8'h07, 8'h15, 8'h59); update("R4", 1'b1);
    setAll(8'h07, 8'hC0, 8'h30, 8'h07, 8'h42, 8'h30); update("R4", 1'b1);
    setAll(8'h07, 8'h80, 8'h30, 8'h07, 8'h42, 8'h30); update("R4", 1'b0);
    setAll(8'h07, 8'h40, 8'h30, 8'h07, 8'h42, 8'h30); update("R4", 1'b0);
    // R5 hourly
    setAll(8'hC3, 8'h15, 8'h30, 8'h23, 8'h15, 8'h30); update("R5", 1'b1);
    setAll(8'hC3, 8'h15, 8'h30, 8'h23, 8'h15, 8'h29); update("R5", 1'b0);
    // R6 per minute
    setAll(8'hE0, 8'hD1, 8'h05, 8'h11, 8'h47, 8'h05); update("R6", 1'b1);
    setAll(8'hE0, 8'hD1, 8'h05, 8'h11, 8'h47, 8'h06); update("R6", 1'b0);
    // R7 every update
    setAll(8'hFF, 8'hC0, 8'hDA, 8'h99, 8'h00, 8'h3C); update("R7", 1'b1);
    // R10 AM/PM bit compared; wildcard still wins
    setAll(8'h81, 8'h00, 8'h00, 8'h01, 8'h00, 8'h00); update("R10", 1'b0);
    setAll(8'h81, 8'h00, 8'h00, 8'h81, 8'h00, 8'h00); update("R10", 1'b1);
    setAll(8'hC5, 8'h00, 8'h00, 8'h85, 8'h00, 8'h00); update("R10", 1'b1);
    // R11 raw bytes
    setAll(8'h00, 8'h3B, 8'h00, 8'h00, 8'h3B, 8'h00); update("R11", 1'b1);
    setAll(8'h00, 8'h5A, 8'h00, 8'h00, 8'h5B, 8'h00); update("R11", 1'b0);

    // R8 matching fields, no strobe
    setAll(8'hFF, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00);
    repeat (4) begin
      @(negedge clk);
      check("R8", matchPulse, 1'b0);
    end

    // R9 held strobe: one pulse only
    @(negedge clk); updDone = 1'b1;
    @(negedge clk); check("R9", matchPulse, 1'b1);
    @(negedge clk); check("R9", matchPulse, 1'b0);
    @(negedge clk); check("R9", matchPulse, 1'b0);
    updDone = 1'b0;
    @(negedge clk); check("R9", matchPulse, 1'b0);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0] c [3];
      logic [7:0] a [3];
      for (int f = 0; f < 3; f++) begin
        int sel;
        c[f] = 8'($urandom);
        sel  = int'($urandom_range(0, 2));
        if (sel == 0)      a[f] = 8'hC0 | 8'($urandom_range(0, 63));
        else if (sel == 1) a[f] = c[f];
        else               a[f] = 8'($urandom_range(0, 191));
      end
      setAll(a[2], a[1], a[0], c[2], c[1], c[0]);
      update("R2", expMatch());
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule